// File: doc/BRIEF.md
# Burst pseudo-SRAM host controller

This block sits between an internal request bus and a 16-bit clock-synchronous pseudo-SRAM. A host hands it one request at a time: a 23-bit start word address, a read or write flag, a burst mode and a latency code. The controller opens the access with chip enable low and a one-cycle address-valid strobe. It then waits out the programmed latency and streams words between the host and the memory, one per clock in which the memory does not signal a stall.

Bursts are 8 words, 16 words or open-ended. Words always follow in ascending address order. An open-ended burst lasts as long as the host keeps its request line high. On writes the host supplies per-word byte enables, and a slot that the host leaves without valid data is written with both byte selects inactive. On reads the controller never drives the shared data bus, and output enable is active only in data cycles. All memory pins run on the controller's clock, so the behaviour is described in whole cycles.

Top module: `psram_burst_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access open, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are 1, and mem_dq_oe, rd_valid and wr_ready are 0. req_ready is 1.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. In the next cycle mem_ce_n goes 0 and mem_adv_n is 0 for exactly that one cycle. mem_addr equals req_addr and stays unchanged while mem_ce_n is 0. mem_we_n is 0 for the whole access of a write (req_write=1) and 1 for a read.
- R3: req_lat is a 4-bit unsigned cycle count L, with codes below 5 treated as 5 and codes above 10 treated as 10. The first data cycle comes exactly L cycles after the address-valid cycle. mem_wait has no effect before that cycle.
- R4: req_mode 0 selects 8 words and 1 selects 16 words. After the last word of such a burst has moved, the next cycle has mem_ce_n=1 and req_ready=1, and a request held high in that cycle is taken at once.
- R5: In a data cycle with mem_wait=1, no word moves: rd_valid and wr_ready stay 0 and the word address does not advance.
- R6: The k-th word moved in a burst (counting from 0) is reported on beat_addr as (start + k) modulo 2^23. This holds in all modes, including across the top of the address space.
- R7: req_mode 2 or 3 selects an open-ended burst. A data cycle in which req_valid is 0 moves no word, and mem_ce_n is 1 in the next cycle. If this happens at the first data cycle, the burst ends with zero words.
- R8: On a read, in every cycle where a word moves, rd_valid is 1 and rd_data equals mem_dq_in. mem_oe_n is 0 only in data cycles, mem_dq_oe stays 0, and both byte selects are 0 in data cycles.
- R9: On a write, mem_dq_oe is 1 and mem_dq_out equals wr_data in every data cycle, and mem_oe_n stays 1. wr_ready marks the cycles where a word moves. mem_lb_n is the inverse of (wr_be[0] and wr_valid) and mem_ub_n is the inverse of (wr_be[1] and wr_valid).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the memory |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; held high to keep an open-ended burst running |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 23 | Start word address |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_mode | input | 2 | 0 = 8 words, 1 = 16 words, 2/3 = open-ended |
| req_lat | input | 4 | Latency code, clamped to 5..10 |
| wr_valid | input | 1 | Host has write data this cycle |
| wr_ready | output | 1 | Write word moved this cycle |
| wr_data | input | 16 | Write data word |
| wr_be | input | 2 | Active-high byte enables, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | Read word moved this cycle |
| rd_data | output | 16 | Read data word |
| beat_addr | output | 23 | Address of the word moving this cycle |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte select (bits 7:0), active low |
| mem_ub_n | output | 1 | High byte select (bits 15:8), active low |
| mem_addr | output | 23 | Memory address bus |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned from the memory |
| mem_wait | input | 1 | Memory stall, active high |

## Verification
The bench covers the smallest and largest latency codes and codes outside the range. A latency counter that is off by one, or that clamps wrongly, moves the first data cycle and misaligns every word compared after it. Stalls are placed in the latency window, on the first data slot and in runs near the end of a burst. A design that counted a stalled slot would end a fixed burst early or write to the wrong address. Bursts cross the top of the address space, and an open-ended burst is stopped both in mid-stream and before its first word, which exposes missing address wrap or a controller that moves one word too many. Write-only slots with the host idle and mixed byte enables check that the byte selects follow each lane. A read-back through a behavioural memory catches a byte lane that is swapped or written unmasked.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int unsigned ADDR_W      = 23;
    localparam int unsigned DATA_W      = 16;
    localparam int unsigned LAT_W       = 4;
    localparam int unsigned LAT_MIN     = 5;
    localparam int unsigned LAT_MAX     = 10;
    localparam int unsigned WORDS_SHORT = 8;
    localparam int unsigned WORDS_LONG  = 16;
    localparam int unsigned BEAT_W      = $clog2(WORDS_LONG) + 1;

    typedef enum logic [1:0] {
        MODE_W8      = 2'd0,
        MODE_W16     = 2'd1,
        MODE_RUN     = 2'd2,
        MODE_RUN_ALT = 2'd3
    } burst_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_LAT,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              write;
        logic              endless;
        logic [LAT_W-1:0]  lat;
        logic [BEAT_W-1:0] limit;
    } access_t;

    function automatic logic [LAT_W-1:0] clamp_latency(input logic [LAT_W-1:0] code);
        if (code < LAT_W'(LAT_MIN)) return LAT_W'(LAT_MIN);
        if (code > LAT_W'(LAT_MAX)) return LAT_W'(LAT_MAX);
        return code;
    endfunction

    function automatic logic [BEAT_W-1:0] burst_limit(input burst_mode_e m);
        case (m)
            MODE_W8:  return BEAT_W'(WORDS_SHORT);
            MODE_W16: return BEAT_W'(WORDS_LONG);
            default:  return '0;
        endcase
    endfunction

    function automatic logic is_endless(input burst_mode_e m);
        return (m == MODE_RUN) || (m == MODE_RUN_ALT);
    endfunction

endpackage

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned CNT_W = psram_pkg::LAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] lat,
    input  logic             beat_done,
    input  logic             stop,
    output phase_e           phase
);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        unique case (ph_q)
            PH_IDLE: if (start) ph_d = PH_ADDR;
            PH_ADDR: begin
                ph_d  = PH_LAT;
                cnt_d = lat - CNT_W'(1);
            end
            PH_LAT: begin
                if (cnt_q <= CNT_W'(1)) ph_d = PH_DATA;
                else                    cnt_d = cnt_q - CNT_W'(1);
            end
            PH_DATA: if (stop || beat_done) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign phase = ph_q;

    logic [CNT_W:0] since_addr;
    always_ff @(posedge clk) begin
        if (rst)                 since_addr <= '0;
        else if (ph_q == PH_ADDR) since_addr <= (CNT_W+1)'(1);
        else if (ph_q == PH_LAT)  since_addr <= since_addr + (CNT_W+1)'(1);
    end

    // R2
    addr_once_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_ADDR) |=> (ph_q == PH_LAT));

    // R3
    lat_window_chk: assert property (@(posedge clk) disable iff (rst)
        ((ph_q == PH_DATA) && ($past(ph_q) == PH_LAT)) |-> (since_addr == {1'b0, lat}));

endmodule

// File: rtl/psram_beats.sv
module psram_beats #(
    parameter int unsigned AW = psram_pkg::ADDR_W,
    parameter int unsigned NW = psram_pkg::BEAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [NW-1:0] limit,
    input  logic          step,
    output logic [AW-1:0] word_addr,
    output logic          last
);

    logic [AW-1:0] addr_q;
    logic [NW-1:0] n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            n_q    <= '0;
        end else if (load) begin
            addr_q <= base;
            n_q    <= '0;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            n_q    <= n_q + NW'(1);
        end
    end

    assign word_addr = addr_q;
    assign last      = (limit != '0) && (n_q == limit - NW'(1));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr_q == $past(addr_q) + AW'(1)));

endmodule

// File: rtl/psram_pins.sv
module psram_pins
    import psram_pkg::*;
#(
    parameter int unsigned DW    = psram_pkg::DATA_W,
    parameter int unsigned NLANE = DW / 8
) (
    input  phase_e           phase,
    input  logic             write,
    input  logic             wr_valid,
    input  logic [NLANE-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    output logic             ce_n,
    output logic             adv_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [NLANE-1:0] bsel_n,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    logic in_data;
    assign in_data = (phase == PH_DATA);

    assign ce_n   = (phase == PH_IDLE);
    assign adv_n  = (phase != PH_ADDR);
    assign we_n   = ~(write && (phase != PH_IDLE));
    assign oe_n   = ~(in_data && !write);
    assign dq_oe  = in_data && write;
    assign dq_out = wr_data;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign bsel_n[i] = !in_data || (write && !(wr_be[i] && wr_valid));
    end

endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = psram_pkg::ADDR_W,
    parameter int unsigned DATA_W = psram_pkg::DATA_W,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic [LAT_W-1:0]  req_lat,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              mem_ce_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              mem_wait
);

    phase_e            phase;
    access_t           acc_q;
    logic [ADDR_W-1:0] base_q;
    logic [LANES-1:0]  bsel_n;
    logic              accept, stop, xfer, last, beat_done;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            acc_q  <= '{write:   req_write,
                        endless: is_endless(burst_mode_e'(req_mode)),
                        lat:     clamp_latency(req_lat),
                        limit:   burst_limit(burst_mode_e'(req_mode))};
            base_q <= req_addr;
        end
    end

    assign stop      = (phase == PH_DATA) && acc_q.endless && !req_valid;
    assign xfer      = (phase == PH_DATA) && !mem_wait && !stop;
    assign beat_done = xfer && last;

    psram_seq #(.CNT_W(LAT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .lat       (acc_q.lat),
        .beat_done (beat_done),
        .stop      (stop),
        .phase     (phase)
    );

    psram_beats #(.AW(ADDR_W), .NW(BEAT_W)) u_beats (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .base      (req_addr),
        .limit     (acc_q.limit),
        .step      (xfer),
        .word_addr (beat_addr),
        .last      (last)
    );

    psram_pins #(.DW(DATA_W), .NLANE(LANES)) u_pins (
        .phase    (phase),
        .write    (acc_q.write),
        .wr_valid (wr_valid),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .ce_n     (mem_ce_n),
        .adv_n    (mem_adv_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .bsel_n   (bsel_n),
        .dq_out   (mem_dq_out),
        .dq_oe    (mem_dq_oe)
    );

    assign mem_lb_n = bsel_n[0];
    assign mem_ub_n = bsel_n[LANES-1];
    assign mem_addr = base_q;
    assign rd_valid = xfer && !acc_q.write;
    assign wr_ready = xfer && acc_q.write;
    assign rd_data  = mem_dq_in;

    // R2
    adv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |=> (mem_adv_n && !mem_ce_n));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R4
    fixed_end_chk: assert property (@(posedge clk) disable iff (rst)
        beat_done |=> (mem_ce_n && req_ready));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wait && !mem_ce_n) |-> (!rd_valid && !wr_ready));

    // R7
    run_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !mem_ce_n) |=> mem_ce_n);

    // R8
    bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

endmodule

// File: tb/psram_burst_ctrl_tb.sv
module psram_burst_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [3:0]  req_lat = 4'd5;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = 2'b11;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [22:0] beat_addr;
    logic        mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [22:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = '0;
    logic        mem_wait = 1'b0;

    always #10 clk = ~clk;

    psram_burst_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_mode(req_mode), .req_lat(req_lat),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_be(wr_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .beat_addr(beat_addr),
        .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run_model = 1'b0;
    bit seen_burst = 1'b0;

    // reference state
    bit m_active = 1'b0;
    bit m_write = 1'b0;
    bit m_cont = 1'b0;
    int m_since = 0;
    int m_lat = 5;
    int m_limit = 8;
    int m_words = 0;
    int m_base = 0;

    // stimulus knobs
    logic [63:0] wait_pat = '0;
    logic [63:0] wv_pat = '1;
    bit          be_mode = 1'b0;

    logic [15:0] mem [int];

    function automatic logic [15:0] mem_read(input int a);
        if (mem.exists(a)) return mem[a];
        return {a[7:0] ^ 8'h5A, a[15:8]};
    endfunction

    function automatic int lat_of(input int code);
        if (code < 5) return 5;
        if (code > 10) return 10;
        return code;
    endfunction

    function automatic int limit_of(input int mode);
        if (mode == 0) return 8;
        if (mode == 1) return 16;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
        end
    endtask

    // input driver, just after each rising edge
    always @(posedge clk) begin
        #1;
        mem_wait  = m_active && wait_pat[m_since % 64];
        mem_dq_in = mem_read((m_base + m_words) & 32'h7FFFFF);
        wr_valid  = wv_pat[(m_active ? m_since : 0) % 64];
        wr_be     = be_mode ? 2'(m_since) : 2'b11;
        wr_data   = {cyc[7:0], ~cyc[7:0] ^ 8'h33};
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // per-cycle comparison and reference update, mid-cycle
    bit          in_data, stop_e, xfer_e;
    int          exp_a;
    logic [1:0]  exp_sel;
    string       tg;
    always @(negedge clk) begin
        if (run_model && !rst) begin
            if (!m_active) begin
                tg = seen_burst ? "R4" : "R1";
                check({mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n,
                       mem_ub_n, rd_valid, wr_ready, req_ready} == 10'b1111011001, tg,
                      {22'd0, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n,
                       mem_ub_n, rd_valid, wr_ready, req_ready}, 32'h3D9);
                if (req_valid) begin
                    m_active = 1'b1;
                    seen_burst = 1'b1;
                    m_since = 0;
                    m_words = 0;
                    m_write = req_write;
                    m_lat = lat_of(int'(req_lat));
                    m_limit = limit_of(int'(req_mode));
                    m_cont = (m_limit == 0);
                    m_base = int'(req_addr);
                end
            end else begin
                in_data = (m_since >= m_lat);
                stop_e  = in_data && m_cont && !req_valid;
                xfer_e  = in_data && !mem_wait && !stop_e;
                exp_a   = (m_base + m_words) & 32'h7FFFFF;
                tg = stop_e ? "R7" : (in_data && mem_wait) ? "R5" :
                     (m_since <= m_lat) ? "R3" : "R4";
                check(!mem_ce_n && !req_ready, "R2", {mem_ce_n, req_ready}, 0);
                check(mem_adv_n == (m_since != 0), "R2", mem_adv_n, (m_since != 0));
                check(mem_addr == m_base[22:0], "R2", mem_addr, m_base);
                check(mem_we_n == !m_write, "R2", mem_we_n, !m_write);
                check(mem_oe_n == !(in_data && !m_write), "R8", mem_oe_n, !(in_data && !m_write));
                check(mem_dq_oe == (in_data && m_write), m_write ? "R9" : "R8",
                      mem_dq_oe, (in_data && m_write));
                if (!in_data)    exp_sel = 2'b11;
                else if (m_write) exp_sel = ~(wr_be & {2{wr_valid}});
                else             exp_sel = 2'b00;
                check({mem_ub_n, mem_lb_n} == exp_sel, m_write ? "R9" : "R8",
                      {mem_ub_n, mem_lb_n}, exp_sel);
                if (in_data && m_write)
                    check(mem_dq_out == wr_data, "R9", mem_dq_out, wr_data);
                check(rd_valid == (xfer_e && !m_write), tg, rd_valid, (xfer_e && !m_write));
                check(wr_ready == (xfer_e && m_write), tg, wr_ready, (xfer_e && m_write));
                if (xfer_e) begin
                    check(beat_addr == exp_a[22:0], "R6", beat_addr, exp_a);
                    if (!m_write)
                        check(rd_data == mem_read(exp_a), "R8", rd_data, mem_read(exp_a));
                    else begin
                        mem[exp_a] = mem_read(exp_a);
                        if (!mem_lb_n) mem[exp_a][7:0]  = mem_dq_out[7:0];
                        if (!mem_ub_n) mem[exp_a][15:8] = mem_dq_out[15:8];
                    end
                end
                if (stop_e) m_active = 1'b0;
                else if (xfer_e) begin
                    m_words++;
                    if (!m_cont && m_words == m_limit) m_active = 1'b0;
                end
                m_since++;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_active) @(negedge clk);
    endtask

    task automatic burst(input int addr, input bit w, input int mode,
                         input int lat, input int hold);
        @(posedge clk);
        #1;
        req_addr  = addr[22:0];
        req_write = w;
        req_mode  = mode[1:0];
        req_lat   = lat[3:0];
        req_valid = 1'b1;
        repeat (hold) @(posedge clk);
        #1 req_valid = 1'b0;
        wait_idle();
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check({mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n,
               mem_ub_n, rd_valid, wr_ready, req_ready} == 10'b1111011001, "R1",
              {22'd0, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n,
               mem_ub_n, rd_valid, wr_ready, req_ready}, 32'h3D9);
        @(posedge clk);
        #1 rst = 1'b0;
        run_model = 1'b1;
        repeat (2) @(posedge clk);

        // R9 R4: 8-word write, shortest latency, no stalls
        burst(32'h100, 1'b1, 0, 5, 1);
        // R8: read it back
        burst(32'h100, 1'b0, 0, 5, 1);

        // R5 R6 R9: 16-word write over the top of the address space, stalls, masked lanes, idle slots
        wait_pat = 64'h0000_0000_0A50_8C06;
        wv_pat   = 64'hFFFF_FFFF_FFFF_B7FF;
        be_mode  = 1'b1;
        burst(32'h7FFFF8, 1'b1, 1, 10, 1);

        // R5 R8: read back with a different latency and stall pattern
        wait_pat = 64'h0000_0000_0066_0300;
        wv_pat   = '1;
        be_mode  = 1'b0;
        burst(32'h7FFFF8, 1'b0, 1, 7, 1);

        // R3: out-of-range latency codes
        wait_pat = '0;
        burst(32'h40, 1'b0, 0, 2, 1);
        burst(32'h40, 1'b0, 0, 15, 1);

        // R7: open-ended read stopped mid-stream
        wait_pat = 64'h0000_0124_0880_2000;
        burst(32'h200, 1'b0, 2, 6, 30);

        // R6 R7: open-ended write across address wrap, alternate mode code
        be_mode = 1'b1;
        burst(32'h7FFFFC, 1'b1, 3, 8, 25);
        be_mode = 1'b0;

        // R7: stopped before the first data cycle
        burst(32'h300, 1'b0, 2, 9, 3);

        // R4: request held high across the end of a fixed burst
        wait_pat = '0;
        burst(32'h10, 1'b0, 0, 5, 20);

        // R6: read back the wrapped write
        wait_pat = 64'h0000_0000_0000_0440;
        burst(32'h7FFFFC, 1'b0, 1, 5, 1);

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule